// File: doc/BRIEF.md
# Dual-Strobe Synchronous SRAM Cycle Controller

This block is the cycle control and storage of a small synchronous SRAM with a common data path. Each word is 18 bits wide. It holds two 8-bit bytes, and each byte has its own parity bit. On every rising clock edge the block decides what kind of cycle is taking place:

- a new access, started by either of two address strobes;
- a burst continue, which moves to the next address;
- a burst suspend, which repeats the current address;
- a deselect;
- an idle cycle.

Three chip enables qualify a new access. One address strobe comes from the processor and the other from the cache controller. The two strobes follow different priority rules and different write rules.

Writes take effect on the clock edge at which they are decoded. A write can cover the whole word or single bytes. Read data comes from the address registered at the previous edge. The data bus is split into `din`, `dout` and a drive enable `dq_oe`. The drive enable is gated by an asynchronous active-low output enable, and it is forced low after any write. The low two address bits step through a four-beat wrap-around burst. The order of that burst is linear or interleaved, as chosen by `burst_il`.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: A new access starts at a rising edge when `ce1_n`=0, `ce2`=1, `ce3_n`=0 and an acted-on strobe is low. The address is then registered and becomes the current address.
- R2: When both strobes are low and `ce1_n`=0, only the processor strobe is acted on. While `ce1_n`=1 the processor strobe is ignored entirely.
- R3: An access started by the processor strobe is a read on its first cycle, whatever the write inputs are. A write may follow on the next edge as a continue or suspend cycle.
- R4: An access started by the controller strobe, with the processor strobe not acted on and a write decoded, writes `din` to the presented address at that same edge.
- R5: Write decode works as follows. `gw_n`=0 writes both bytes. Otherwise, with `bwe_n`=0, each `bw_n[k]`=0 writes byte k. Byte 0 is `din[7:0]` plus parity `din[16]`; byte 1 is `din[15:8]` plus parity `din[17]`. `bwe_n`=1 with `gw_n`=1 means a read.
- R6: With no strobe acted on, a burst in progress and `adv_n`=0, the cycle moves to the next burst address. The low two address bits are a wrap-around count k from the first address f: they are f^k when `burst_il`=1 and (f+k) mod 4 when `burst_il`=0. The upper address bits stay the same, and the chip enables are not examined.
- R7: With no strobe acted on, a burst in progress and `adv_n`=1, the cycle repeats the current address, for a read or a write.
- R8: An acted-on strobe with `ce2`=0 or `ce3_n`=1, or a controller strobe with `ce1_n`=1, deselects the block. The bus then goes to high-Z, and later strobe-free cycles access nothing until a new access starts.
- R9: `dq_oe` is 1 only while `oe_n`=0 and the cycle registered at the last edge was a selected read. Any write, including a single-byte write, leaves `dq_oe`=0 whatever `oe_n` is.
- R10: `dout` holds the word stored at the address registered at the previous rising edge, including data written at that edge.
- R11: Bytes that a byte write does not select keep their previous contents.
- R12: After reset, no burst is in progress and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_il | input | 1 | 1 selects interleaved burst order, 0 selects linear |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | 2 | Per-byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| din | input | 18 | Write data: two bytes in bits 15:0, parity in 17:16 |
| dout | output | 18 | Read data for the registered address |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench builds the block with DEPTH=64. That keeps a six-bit address, so the upper address bits can be checked to hold steady while the low two bits wrap within each four-word burst group. A small depth also makes it cheap to model the whole storage with associative arrays in the bench. Both burst orders are exercised from first addresses that are not aligned, so wrap-around is reached in linear and in interleaved order. Strobe conflicts, chip-enable masking and byte-lane writes are all driven against the same reference model.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst_il,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [1:0]    bw_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [17:0]   din,
  output logic [17:0]   dout,
  output logic          dq_oe
);

  logic          act_q, rd_q;
  logic [AW-1:0] cur_q;
  logic [1:0]    first_q, cnt_q;

  wire adsp_hit = !adsp_n && !ce1_n;
  wire adsc_hit = !adsc_n && !adsp_hit;
  wire strobe   = adsp_hit || adsc_hit;
  wire chip_sel = !ce1_n && ce2 && !ce3_n;
  wire start    = strobe && chip_sel;
  wire desel    = strobe && !chip_sel;
  wire carry    = !strobe && act_q;

  wire [1:0] lane_we = {2{!gw_n}} | ({2{!bwe_n}} & ~bw_n);
  wire       wr_req  = |lane_we;
  wire       wr_fire = (start && adsc_hit && wr_req) || (carry && wr_req);

  wire [1:0] cnt_nx = cnt_q + {1'b0, !adv_n};
  logic [1:0]    low_nx;
  logic [AW-1:0] cyc_addr;

  always_comb begin
    low_nx   = burst_il ? (first_q ^ cnt_nx) : (first_q + cnt_nx);
    cyc_addr = start ? addr : {cur_q[AW-1:2], low_nx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      cur_q   <= '0;
      first_q <= '0;
      cnt_q   <= '0;
    end else if (start) begin
      act_q   <= 1'b1;
      rd_q    <= !(adsc_hit && wr_req);
      cur_q   <= addr;
      first_q <= addr[1:0];
      cnt_q   <= '0;
    end else if (desel) begin
      act_q <= 1'b0;
      rd_q  <= 1'b0;
    end else if (carry) begin
      rd_q  <= !wr_req;
      cur_q <= cyc_addr;
      cnt_q <= cnt_nx;
    end else begin
      rd_q <= 1'b0;
    end
  end

  logic [8:0] rd_lane [2];

  for (genvar b = 0; b < 2; b++) begin : g_lane
    logic [8:0] store [DEPTH];
    always_ff @(posedge clk)
      if (wr_fire && lane_we[b])
        store[cyc_addr] <= {din[16+b], din[8*b +: 8]};
    assign rd_lane[b] = store[cur_q];
  end

  assign dout  = {rd_lane[1][8], rd_lane[0][8], rd_lane[1][7:0], rd_lane[0][7:0]};
  assign dq_oe = !oe_n && rd_q;

  p_start_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cur_q == $past(addr)));

  p_adsp_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && adsp_hit) |=> (dq_oe == !oe_n));

  p_desel_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !dq_oe);

  p_write_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !dq_oe);

  p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  p_suspend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && adv_n) |=> $stable(cur_q));

endmodule

// File: tb/test_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module test_sram_cycle_ctrl;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic burst_il = 0, ce1_n = 1, ce2 = 0, ce3_n = 1;
  logic adsp_n = 1, adsc_n = 1, adv_n = 1, gw_n = 1, bwe_n = 1, oe_n = 1;
  logic [1:0] bw_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic dq_oe;

  always #2.5 clk = ~clk;

  sram_cycle_ctrl #(.DEPTH(DEPTH)) i_sram_cycle_ctrl (
    .clk, .rst_n, .burst_il, .ce1_n, .ce2, .ce3_n, .adsp_n, .adsc_n, .adv_n,
    .gw_n, .bwe_n, .bw_n, .oe_n, .addr, .din, .dout, .dq_oe);

  int vectors = 0, miscompares = 0;
  logic [8:0] m_lo [int];
  logic [8:0] m_hi [int];
  bit m_act = 0, m_rd = 0;
  int m_cur = 0, m_first = 0, m_k = 0;

  task automatic model_step();
    bit p_on, c_on, sel, wr;
    bit [1:0] we;
    int tgt;
    p_on = !adsp_n && !ce1_n;
    c_on = !adsc_n && !p_on;
    sel  = !ce1_n && ce2 && !ce3_n;
    we[0] = !gw_n || (!bwe_n && !bw_n[0]);
    we[1] = !gw_n || (!bwe_n && !bw_n[1]);
    wr = we != 0;
    if ((p_on || c_on) && sel) begin
      tgt = addr; m_act = 1; m_first = addr % 4; m_k = 0; m_cur = tgt;
      if (c_on && wr) m_rd = 0; else begin m_rd = 1; wr = 0; end
    end else if (p_on || c_on) begin
      m_act = 0; m_rd = 0; wr = 0; tgt = 0;
    end else if (m_act) begin
      if (!adv_n) m_k = (m_k + 1) % 4;
      tgt = (m_cur / 4) * 4 + (burst_il ? (m_first ^ m_k) : ((m_first + m_k) % 4));
      m_cur = tgt; m_rd = !wr;
    end else begin
      m_rd = 0; wr = 0; tgt = 0;
    end
    if (wr && we[0]) m_lo[tgt] = {din[16], din[7:0]};
    if (wr && we[1]) m_hi[tgt] = {din[17], din[15:8]};
  endtask

  task automatic compare(input string tag);
    bit eoe;
    logic [17:0] ed;
    eoe = !oe_n && m_rd;
    vectors++;
    if (dq_oe !== eoe) begin
      miscompares++;
      $display("FAIL %s dq_oe actual %0b expected %0b", tag, dq_oe, eoe);
    end
    if (eoe && m_lo.exists(m_cur) && m_hi.exists(m_cur)) begin
      ed = {m_hi[m_cur][8], m_lo[m_cur][8], m_hi[m_cur][7:0], m_lo[m_cur][7:0]};
      vectors++;
      if (dout !== ed) begin
        miscompares++;
        $display("FAIL %s dout actual %h expected %h (addr %0d)", tag, dout, ed, m_cur);
      end
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11;
    ce1_n = 0; ce2 = 1; ce3_n = 0; oe_n = 0;
  endtask

  task automatic c_write(input string tag, input int a, input logic [17:0] d);
    idle(); adsc_n = 0; gw_n = 0; addr = AW'(a); din = d; tick(tag);
  endtask

  task automatic c_read(input string tag, input int a);
    idle(); adsc_n = 0; addr = AW'(a); tick(tag);
  endtask

  task automatic cont(input string tag, input bit adv, input bit w, input logic [17:0] d);
    idle(); adv_n = !adv; gw_n = !w; din = d; ce1_n = 1; ce2 = 0; tick(tag);
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    tick("R12");
    vectors++;
    if (dq_oe !== 1'b0) begin
      miscompares++; $display("FAIL R12 dq_oe actual %0b expected 0", dq_oe);
    end

    c_write("R4", 16, 18'h3A5A5);
    c_read("R10", 16);
    c_write("R4", 17, 18'h1C3C3);
    c_read("R10", 17);

    burst_il = 0;
    idle(); adsc_n = 0; bwe_n = 0; bw_n = 2'b00; addr = 6'h21; din = 18'h01111; tick("R5");
    cont("R6", 1, 1, 18'h02222);
    cont("R6", 1, 1, 18'h13333);
    cont("R6", 1, 1, 18'h24444);
    c_read("R6", 33);
    for (int i = 0; i < 3; i++) cont("R6", 1, 0, 0);
    burst_il = 1;
    c_read("R6", 34);
    for (int i = 0; i < 3; i++) cont("R6", 1, 0, 0);
    c_read("R6", 35);
    for (int i = 0; i < 3; i++) cont("R6", 1, 0, 0);

    c_read("R7", 35);
    cont("R7", 0, 0, 0);
    cont("R7", 0, 0, 0);
    cont("R7", 0, 1, 18'h35A5A);
    c_read("R7", 35);

    idle(); adsc_n = 0; bwe_n = 0; bw_n = 2'b10; addr = 16; din = 18'h100EE; tick("R11");
    c_read("R11", 16);
    idle(); adsc_n = 0; bwe_n = 0; bw_n = 2'b01; addr = 17; din = 18'h2BB00; tick("R11");
    c_read("R11", 17);

    idle(); adsp_n = 0; gw_n = 0; addr = 33; din = 18'h3FFFF; tick("R3");
    cont("R3", 0, 1, 18'h0ABCD);
    c_read("R3", 33);

    idle(); adsp_n = 0; adsc_n = 0; gw_n = 0; addr = 34; din = 18'h00000; tick("R2");
    c_read("R2", 34);

    c_read("R2", 36);
    idle(); adsp_n = 0; ce1_n = 1; ce2 = 0; addr = 5; tick("R2");
    idle(); adsp_n = 0; ce1_n = 1; addr = 5; adv_n = 0; tick("R2");
    idle(); adsc_n = 0; ce1_n = 1; addr = 16; tick("R8");
    cont("R8", 1, 0, 0);
    cont("R8", 0, 1, 18'h3FFFF);
    c_read("R8", 16);

    idle(); adsc_n = 0; ce2 = 0; addr = 16; tick("R1");
    idle(); adsp_n = 0; ce3_n = 1; addr = 16; tick("R1");
    idle(); adsp_n = 0; addr = 16; tick("R1");

    c_read("R9", 17);
    oe_n = 1; #1; compare("R9");
    idle(); adsc_n = 0; oe_n = 1; addr = 17; tick("R9");
    idle(); adsc_n = 0; bwe_n = 0; bw_n = 2'b10; addr = 18; din = 18'h00077; tick("R9");
    cont("R9", 0, 0, 0);

    idle(); adsc_n = 0; bwe_n = 1; bw_n = 2'b00; addr = 17; din = 18'h3FFFF; tick("R5");
    c_read("R5", 17);

    idle();
    repeat (2) tick("R12");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule